// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a configuration register file that a host reaches through two byte-wide I/O ports. One port carries a register index and the other carries the data of the indexed register. After reset the port is locked. It unlocks only when a fixed four-byte key has been written to the index port. While it is unlocked, the host writes a register number to the index port and then reads or writes that register through the data port.

A few global registers are always visible: the device selector, a 16-bit chip identifier and a revision byte. Indices 0x30 and above belong to whichever device bank the selector names. Each bank has an activate bit and a 16-bit base address. The bank at selector value 7 also has four watchdog configuration bytes. The stored values leave the block as plain output pins, which the devices behind each bank use.

Every access is a single-cycle strobe that the block always accepts. There is no back-pressure, so the access interface carries no valid/ready pair. Read data is registered and appears after the clock edge that samples the read strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, `io_rdata` is 0xFF, the device selector is 0, and every bank output (`dev_active`, `dev_base`, `wdt_ctrl`, `wdt_cfg`, `wdt_count`) is 0.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (address 0x002E) unlocks the port. `cfg_unlocked` is high from the clock edge that takes the fourth byte.
- R3: A wrong byte during key entry sends the matcher back to the start. If that wrong byte is 0x87, it counts as the first key byte. So 87 01 87 01 55 55 unlocks, 87 87 01 55 55 unlocks, and 87 01 55 00 55 does not.
- R4: While unlocked, a write of 0x02 to the data port (address 0x002F) with index 0x02 latched locks the port again. Any other value written to index 0x02 has no effect.
- R5: While locked, a data-port write changes no register. A read of either port returns 0xFF. Index-port writes go only to the key matcher.
- R6: While unlocked, an index-port write latches the index, and an index-port read returns the latched index.
- R7: The global registers are:
  - 0x07: the device selector, read/write.
  - 0x20: chip ID bits 15:8.
  - 0x21: chip ID bits 7:0.
  - 0x22: the revision in bits 3:0 and 0 in bits 7:4.

  Every other index below 0x30 reads 0x00 and ignores writes.
- R8: Indices at or above 0x30 reach the bank named by the selector:
  - 0x30: the activate bit in bit 0, with bits 7:1 reading 0.
  - 0x60: base address bits 15:8.
  - 0x61: base address bits 7:0.

  Bank n drives `dev_active[n]` and `dev_base[16n+15:16n]`.
- R9: In the bank at selector value 7, index 0x71 is the watchdog control byte and 0x72 the watchdog config byte. Index 0x73 holds bits 7:0 of the 16-bit watchdog count and 0x74 holds bits 15:8. All four are readable and writable and drive `wdt_ctrl`, `wdt_cfg` and `wdt_count`.
- R10: An index the selected bank does not implement reads 0x00 and ignores writes. A selector value of N_DEV or more selects no bank.
- R11: `io_rdata` changes only at an edge where a read of one of the two port addresses is sampled. Accesses to other addresses have no effect. When a write and a read are strobed in the same cycle, the write takes effect and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_unlocked | output | 1 | High while configuration access is open |
| dev_active | output | N_DEV | Activate bit of each bank |
| dev_base | output | 16*N_DEV | Base address of each bank, bank n at bits 16n+15:16n |
| wdt_ctrl | output | 8 | Watchdog control byte |
| wdt_cfg | output | 8 | Watchdog config byte |
| wdt_count | output | 16 | Watchdog count value |

## Verification
Several properties are checked on every cycle. The port can unlock only on the edge that takes the final key byte, and it is locked on the cycle after the exit write. While locked, no bank output or selector value moves and data reads yield 0xFF. The read data holds between sampled reads, and a read of an absent bank yields zero. Other behaviours can only be shown by the bench's scenarios: the exact key ordering, matcher recovery on a stray 0x87, the byte order of the chip ID and base address, and the isolation of one bank's registers from another's.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int KEY_LEN = 4;
  localparam int KEY_W   = $clog2(KEY_LEN);
  localparam int BASE_W  = 16;

  localparam logic [7:0] IDX_EXIT   = 8'h02;
  localparam logic [7:0] EXIT_VAL   = 8'h02;
  localparam logic [7:0] IDX_SEL    = 8'h07;
  localparam logic [7:0] IDX_ID_HI  = 8'h20;
  localparam logic [7:0] IDX_ID_LO  = 8'h21;
  localparam logic [7:0] IDX_REV    = 8'h22;
  localparam logic [7:0] BANK_FIRST = 8'h30;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_BASE_H = 8'h60;
  localparam logic [7:0] IDX_BASE_L = 8'h61;
  localparam logic [7:0] IDX_WCTRL  = 8'h71;
  localparam logic [7:0] IDX_WCFG   = 8'h72;
  localparam logic [7:0] IDX_WCNT_L = 8'h73;
  localparam logic [7:0] IDX_WCNT_H = 8'h74;

  function automatic logic [7:0] key_byte(input logic [KEY_W-1:0] pos);
    case (pos)
      2'd0:    key_byte = 8'h87;
      2'd1:    key_byte = 8'h01;
      default: key_byte = 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/sio_key_match.sv
module sio_key_match
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [7:0] byte_in,
  input  logic       relock,
  output logic       unlocked
);
  logic [KEY_W-1:0] stage_q;
  logic             match;
  logic             last;

  assign match = (byte_in == key_byte(stage_q));
  assign last  = (stage_q == KEY_W'(KEY_LEN-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q  <= '0;
      unlocked <= 1'b0;
    end else if (relock) begin
      stage_q  <= '0;
      unlocked <= 1'b0;
    end else if (step && !unlocked) begin
      if (match) begin
        if (last) begin
          stage_q  <= '0;
          unlocked <= 1'b1;
        end else begin
          stage_q <= stage_q + 1'b1;
        end
      end else if (byte_in == key_byte('0)) begin
        stage_q <= KEY_W'(1);
      end else begin
        stage_q <= '0;
      end
    end
  end

  // R2
  key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(step && byte_in == key_byte(KEY_W'(KEY_LEN-1))));

  // R2
  key_stage_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |-> stage_q == '0);

  // R4
  key_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    relock |=> !unlocked);
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
  import sio_cfg_pkg::*;
#(
  parameter int N_DEV = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [7:0]              sel,
  input  logic [7:0]              idx,
  input  logic [7:0]              wdata,
  output logic [7:0]              rd_val,
  output logic [N_DEV-1:0]        dev_active,
  output logic [N_DEV*BASE_W-1:0] dev_base
);
  logic [N_DEV-1:0]  act_w;
  logic [BASE_W-1:0] base_w [N_DEV];

  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    logic              act_r;
    logic [BASE_W-1:0] base_r;
    logic              hit;

    assign hit = we && (sel == 8'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_r  <= 1'b0;
        base_r <= '0;
      end else if (hit) begin
        case (idx)
          IDX_ACT:    act_r         <= wdata[0];
          IDX_BASE_H: base_r[15:8]  <= wdata;
          IDX_BASE_L: base_r[7:0]   <= wdata;
          default:    ;
        endcase
      end
    end

    assign act_w[g]  = act_r;
    assign base_w[g] = base_r;
    assign dev_active[g] = act_r;
    assign dev_base[g*BASE_W +: BASE_W] = base_r;
  end

  always_comb begin
    rd_val = 8'h00;
    for (int i = 0; i < N_DEV; i++) begin
      if (sel == 8'(i)) begin
        case (idx)
          IDX_ACT:    rd_val = {7'b0, act_w[i]};
          IDX_BASE_H: rd_val = base_w[i][15:8];
          IDX_BASE_L: rd_val = base_w[i][7:0];
          default:    rd_val = 8'h00;
        endcase
      end
    end
  end

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(dev_active) && $stable(dev_base));
endmodule

// File: rtl/sio_wdt_regs.sv
module sio_wdt_regs
  import sio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic [7:0]  rd_val,
  output logic [7:0]  wdt_ctrl,
  output logic [7:0]  wdt_cfg,
  output logic [15:0] wdt_count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdt_ctrl  <= '0;
      wdt_cfg   <= '0;
      wdt_count <= '0;
    end else if (we) begin
      case (idx)
        IDX_WCTRL:  wdt_ctrl         <= wdata;
        IDX_WCFG:   wdt_cfg          <= wdata;
        IDX_WCNT_L: wdt_count[7:0]   <= wdata;
        IDX_WCNT_H: wdt_count[15:8]  <= wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_WCTRL:  rd_val = wdt_ctrl;
      IDX_WCFG:   rd_val = wdt_cfg;
      IDX_WCNT_L: rd_val = wdt_count[7:0];
      IDX_WCNT_H: rd_val = wdt_count[15:8];
      default:    rd_val = 8'h00;
    endcase
  end

  // R9
  wdt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(wdt_ctrl) && $stable(wdt_cfg) && $stable(wdt_count));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          N_DEV     = 11,
  parameter logic [7:0]  WDT_SEL   = 8'h07,
  parameter logic [15:0] CHIP_ID   = 16'h8716,
  parameter logic [3:0]  CHIP_REV  = 4'h3,
  parameter logic [15:0] IDX_ADDR  = 16'h002E,
  parameter logic [15:0] DATA_ADDR = 16'h002F
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             io_addr,
  input  logic                    io_wr,
  input  logic                    io_rd,
  input  logic [7:0]              io_wdata,
  output logic [7:0]              io_rdata,
  output logic                    cfg_unlocked,
  output logic [N_DEV-1:0]        dev_active,
  output logic [N_DEV*BASE_W-1:0] dev_base,
  output logic [7:0]              wdt_ctrl,
  output logic [7:0]              wdt_cfg,
  output logic [15:0]             wdt_count
);
  logic       at_idx, at_data;
  logic       wr_idx, wr_data, rd_acc;
  logic       data_we, relock, bank_we, wdt_we;
  logic [7:0] idx_q, sel_q;
  logic [7:0] bank_rd, wdt_rd, reg_rd;

  assign at_idx  = (io_addr == IDX_ADDR);
  assign at_data = (io_addr == DATA_ADDR);
  assign wr_idx  = io_wr && at_idx;
  assign wr_data = io_wr && at_data;
  assign rd_acc  = io_rd && !io_wr && (at_idx || at_data);
  assign data_we = wr_data && cfg_unlocked;
  assign relock  = data_we && (idx_q == IDX_EXIT) && (io_wdata == EXIT_VAL);
  assign bank_we = data_we && (idx_q >= BANK_FIRST);
  assign wdt_we  = bank_we && (sel_q == WDT_SEL);

  sio_key_match u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (wr_idx && !cfg_unlocked),
    .byte_in  (io_wdata),
    .relock   (relock),
    .unlocked (cfg_unlocked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      sel_q <= '0;
    end else begin
      if (wr_idx && cfg_unlocked) idx_q <= io_wdata;
      if (data_we && idx_q == IDX_SEL) sel_q <= io_wdata;
    end
  end

  sio_dev_bank #(.N_DEV(N_DEV)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (bank_we),
    .sel        (sel_q),
    .idx        (idx_q),
    .wdata      (io_wdata),
    .rd_val     (bank_rd),
    .dev_active (dev_active),
    .dev_base   (dev_base)
  );

  sio_wdt_regs u_wdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wdt_we),
    .idx       (idx_q),
    .wdata     (io_wdata),
    .rd_val    (wdt_rd),
    .wdt_ctrl  (wdt_ctrl),
    .wdt_cfg   (wdt_cfg),
    .wdt_count (wdt_count)
  );

  always_comb begin
    if (idx_q < BANK_FIRST) begin
      case (idx_q)
        IDX_SEL:   reg_rd = sel_q;
        IDX_ID_HI: reg_rd = CHIP_ID[15:8];
        IDX_ID_LO: reg_rd = CHIP_ID[7:0];
        IDX_REV:   reg_rd = {4'h0, CHIP_REV};
        default:   reg_rd = 8'h00;
      endcase
    end else if (sel_q == WDT_SEL) begin
      reg_rd = bank_rd | wdt_rd;
    end else begin
      reg_rd = bank_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rdata <= 8'hFF;
    end else if (rd_acc) begin
      if (!cfg_unlocked) io_rdata <= 8'hFF;
      else if (at_idx)   io_rdata <= idx_q;
      else               io_rdata <= reg_rd;
    end
  end

  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_unlocked |=> $stable(dev_active) && $stable(dev_base) && $stable(wdt_ctrl)
                      && $stable(wdt_count) && $stable(sel_q));

  // R5
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && at_data && !cfg_unlocked) |=> io_rdata == 8'hFF);

  // R10
  absent_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && at_data && cfg_unlocked && idx_q >= BANK_FIRST
     && sel_q >= 8'(N_DEV) && sel_q != WDT_SEL) |=> io_rdata == 8'h00);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && !io_wr && (at_idx || at_data)) |=> $stable(io_rdata));
endmodule

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;
  localparam int N_DEV = 11;
  localparam logic [15:0] IA = 16'h002E;
  localparam logic [15:0] DA = 16'h002F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0;
  logic io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic cfg_unlocked;
  logic [N_DEV-1:0] dev_active;
  logic [N_DEV*16-1:0] dev_base;
  logic [7:0] wdt_ctrl, wdt_cfg;
  logic [15:0] wdt_count;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sio_cfg_port u_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_unlocked(cfg_unlocked),
    .dev_active(dev_active), .dev_base(dev_base), .wdt_ctrl(wdt_ctrl),
    .wdt_cfg(wdt_cfg), .wdt_count(wdt_count)
  );

  // vector: {req[3:0], is_read, on_data_port, wdata[7:0], expect[7:0]}
  localparam int N_VEC = 63;
  localparam logic [21:0] VEC [N_VEC] = '{
    {4'd5, 1'b1, 1'b1, 8'h00, 8'hFF},  // R5 locked data read
    {4'd5, 1'b0, 1'b1, 8'h07, 8'h00},  // R5 locked data write
    {4'd5, 1'b1, 1'b0, 8'h00, 8'hFF},  // R5 locked index read
    {4'd2, 1'b0, 1'b0, 8'h87, 8'h00},  // R2 key
    {4'd2, 1'b0, 1'b0, 8'h01, 8'h00},
    {4'd2, 1'b0, 1'b0, 8'h55, 8'h00},
    {4'd2, 1'b0, 1'b0, 8'h55, 8'h00},
    {4'd6, 1'b0, 1'b0, 8'h07, 8'h00},  // R6 index latch
    {4'd5, 1'b1, 1'b1, 8'h00, 8'h00},  // R5 selector untouched by locked write
    {4'd6, 1'b1, 1'b0, 8'h00, 8'h07},  // R6 index read back
    {4'd7, 1'b0, 1'b0, 8'h20, 8'h00},  // R7 id high
    {4'd7, 1'b1, 1'b1, 8'h00, 8'h87},
    {4'd7, 1'b0, 1'b0, 8'h21, 8'h00},
    {4'd7, 1'b1, 1'b1, 8'h00, 8'h16},
    {4'd7, 1'b0, 1'b0, 8'h22, 8'h00},
    {4'd7, 1'b1, 1'b1, 8'h00, 8'h03},
    {4'd7, 1'b0, 1'b1, 8'h5A, 8'h00},  // R7 read-only write
    {4'd7, 1'b1, 1'b1, 8'h00, 8'h03},
    {4'd7, 1'b0, 1'b0, 8'h07, 8'h00},  // R7 selector rw
    {4'd7, 1'b0, 1'b1, 8'h07, 8'h00},
    {4'd7, 1'b1, 1'b1, 8'h00, 8'h07},
    {4'd9, 1'b0, 1'b0, 8'h71, 8'h00},  // R9 watchdog regs
    {4'd9, 1'b0, 1'b1, 8'hA5, 8'h00},
    {4'd9, 1'b1, 1'b1, 8'h00, 8'hA5},
    {4'd9, 1'b0, 1'b0, 8'h73, 8'h00},
    {4'd9, 1'b0, 1'b1, 8'h3C, 8'h00},
    {4'd9, 1'b0, 1'b0, 8'h74, 8'h00},
    {4'd9, 1'b0, 1'b1, 8'h00, 8'h00},
    {4'd9, 1'b1, 1'b1, 8'h00, 8'h00},
    {4'd9, 1'b0, 1'b0, 8'h73, 8'h00},
    {4'd9, 1'b1, 1'b1, 8'h00, 8'h3C},
    {4'd8, 1'b0, 1'b0, 8'h30, 8'h00},  // R8 activate
    {4'd8, 1'b0, 1'b1, 8'hFF, 8'h00},
    {4'd8, 1'b1, 1'b1, 8'h00, 8'h01},
    {4'd8, 1'b0, 1'b0, 8'h60, 8'h00},  // R8 base
    {4'd8, 1'b0, 1'b1, 8'h12, 8'h00},
    {4'd8, 1'b0, 1'b0, 8'h61, 8'h00},
    {4'd8, 1'b0, 1'b1, 8'h34, 8'h00},
    {4'd8, 1'b1, 1'b1, 8'h00, 8'h34},
    {4'd8, 1'b0, 1'b0, 8'h60, 8'h00},
    {4'd8, 1'b1, 1'b1, 8'h00, 8'h12},
    {4'd8, 1'b0, 1'b0, 8'h07, 8'h00},  // R8 switch to bank 2
    {4'd8, 1'b0, 1'b1, 8'h02, 8'h00},
    {4'd8, 1'b0, 1'b0, 8'h60, 8'h00},
    {4'd8, 1'b1, 1'b1, 8'h00, 8'h00},
    {4'd10, 1'b0, 1'b0, 8'h71, 8'h00}, // R10 no watchdog regs in bank 2
    {4'd10, 1'b1, 1'b1, 8'h00, 8'h00},
    {4'd10, 1'b0, 1'b1, 8'h99, 8'h00},
    {4'd10, 1'b0, 1'b0, 8'h07, 8'h00},
    {4'd10, 1'b0, 1'b1, 8'h07, 8'h00},
    {4'd10, 1'b0, 1'b0, 8'h71, 8'h00},
    {4'd10, 1'b1, 1'b1, 8'h00, 8'hA5},
    {4'd10, 1'b0, 1'b0, 8'h07, 8'h00}, // R10 selector past last bank
    {4'd10, 1'b0, 1'b1, 8'h0C, 8'h00},
    {4'd10, 1'b0, 1'b0, 8'h30, 8'h00},
    {4'd10, 1'b0, 1'b1, 8'h01, 8'h00},
    {4'd10, 1'b1, 1'b1, 8'h00, 8'h00},
    {4'd4, 1'b0, 1'b0, 8'h02, 8'h00},  // R4 exit index
    {4'd4, 1'b0, 1'b1, 8'h05, 8'h00},  // wrong value
    {4'd4, 1'b1, 1'b0, 8'h00, 8'h02},  // still open
    {4'd4, 1'b0, 1'b1, 8'h02, 8'h00},  // exit
    {4'd4, 1'b1, 1'b1, 8'h00, 8'hFF},
    {4'd4, 1'b1, 1'b0, 8'h00, 8'hFF}
  };

  task automatic check(input int req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic key(input logic [7:0] b);
    wr(IA, b);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(1, "rdata", io_rdata, 8'hFF);
    check(1, "unlocked", cfg_unlocked, 1'b0);
    check(1, "active", dev_active, 0);
    check(1, "wdt", {wdt_ctrl, wdt_cfg, wdt_count}, 0);

    for (int i = 0; i < N_VEC; i++) begin
      logic [21:0] v;
      v = VEC[i];
      if (v[17]) begin
        rd(v[16] ? DA : IA);
        check(int'(v[21:18]), $sformatf("vector %0d", i), io_rdata, v[7:0]);
      end else begin
        wr(v[16] ? DA : IA, v[15:8]);
      end
    end

    // R8 R9 R10 outputs after the table
    check(8, "dev_active", dev_active, 11'h080);
    check(8, "dev_base7", dev_base[7*16 +: 16], 16'h1234);
    check(9, "wdt_ctrl", wdt_ctrl, 8'hA5);
    check(9, "wdt_cfg", wdt_cfg, 8'h00);
    check(9, "wdt_count", wdt_count, 16'h003C);
    check(4, "locked after exit", cfg_unlocked, 1'b0);

    // R3 recovery on repeated first byte
    key(8'h87); key(8'h01); key(8'h87); key(8'h01); key(8'h55); key(8'h55);
    check(3, "87 01 87 01 55 55", cfg_unlocked, 1'b1);
    wr(IA, 8'h02); wr(DA, 8'h02);
    check(4, "relock", cfg_unlocked, 1'b0);
    key(8'h87); key(8'h01); key(8'h55); key(8'h00); key(8'h55);
    check(3, "87 01 55 00 55", cfg_unlocked, 1'b0);
    key(8'h87); key(8'h87); key(8'h01); key(8'h55);
    check(2, "three bytes only", cfg_unlocked, 1'b0);
    key(8'h55);
    check(3, "87 87 01 55 55", cfg_unlocked, 1'b1);

    // R7 unimplemented global index
    wr(IA, 8'h10); wr(DA, 8'h44); rd(DA);
    check(7, "global idx 0x10", io_rdata, 8'h00);

    // R11 read hold and address decode
    wr(IA, 8'h07); rd(DA);
    check(11, "selector kept", io_rdata, 8'h0C);
    rd(16'h0080);
    check(11, "foreign read holds", io_rdata, 8'h0C);
    wr(16'h012F, 8'h03); rd(DA);
    check(11, "foreign write ignored", io_rdata, 8'h0C);
    @(negedge clk);
    io_addr = DA; io_wdata = 8'h07; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    check(11, "wr+rd drops read", io_rdata, 8'h0C);
    rd(DA);
    check(11, "wr+rd write lands", io_rdata, 8'h07);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule